// File: doc/BRIEF.md
# Constant-Frequency PWM Counter Stage

This block turns a stream of rate ticks into a pulse-width-modulated level. An upstream frequency source supplies a one-cycle `tick` enable in the system clock domain. Each accepted tick moves an internal counter forward by one. The counter climbs from zero up to the programmed period value, then returns to zero. A full output cycle therefore spans the period value plus one ticks. The output stays high while the count is below the programmed on value, so each cycle opens with a high phase of exactly that many ticks.

Period and on values are offered on plain input buses. While the stage runs, the working copies of these values change only at the moment the counter returns to zero. A change made in the middle of a cycle never cuts a pulse short or stretches it. While `run` is low, the counter stays at zero and the output is low. The working copies follow the inputs during that time, so the first cycle after start already uses the values presented. An on value of zero keeps the output low. An on value larger than the period value keeps the output high, for example on 0xFF with period 0xFE.

A one-cycle `cycle_end` strobe marks the tick on which the counter returns to zero. Upstream logic can use it to line up new settings with the cycle boundary.

Top module: `cfpwm_stage`

## Requirements
- R1: After reset, `pwm_out` and `cycle_end` are both low.
- R2: While `run` is low, `pwm_out` and `cycle_end` stay low whatever `tick` does. The counter is held at zero, so after `run` rises the output shows a cycle that starts from count zero.
- R3: The counter moves only on clock cycles where `tick` is high. On other cycles the output level holds, and `cycle_end` is raised only in a cycle with `tick` high.
- R4: With period value P, `cycle_end` pulses once every P+1 ticks, on the tick at which the count equals P. The count is zero afterwards.
- R5: With on value N, where N ≤ P, `pwm_out` is high for the first N ticks of every cycle and low for the remaining P+1-N ticks.
- R6: When the on value is greater than the period value (for example on = 0xFF, period = 0xFE), `pwm_out` stays continuously high while running.
- R7: An on value of 0 keeps `pwm_out` continuously low while running, and `cycle_end` still pulses every P+1 ticks.
- R8: Period or on values changed while running take effect only after the next `cycle_end`. The cycle in progress completes with the old values.
- R9: Values presented while `run` is low are in force from the first cycle after `run` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start control; low holds the stage idle |
| tick | input | 1 | One-cycle rate enable from the frequency source |
| period_in | input | CNT_W | Period value P; a cycle lasts P+1 ticks |
| on_in | input | CNT_W | On value N; high ticks per cycle |
| pwm_out | output | 1 | Modulated output level |
| cycle_end | output | 1 | One-cycle strobe on the wrapping tick |

## Verification
The assertions assume that `tick` and `run` are synchronous to `clk` and never change within a cycle. They also assume that the working period and on values move only at a wrap or while idle, and that reset is applied from time zero. The stimulus drives every input one time unit after a rising edge and samples just before the next edge. Ticks are generated as regular patterns, either every cycle or every few cycles. Settings change only on idle cycles, or at deliberately chosen mid-cycle points in the shadowing scenario.

// File: rtl/cfpwm_pkg.sv
package cfpwm_pkg;
   // Default counter width and the smallest width the stage accepts.
   localparam int DEF_CNT_W = 8;
   localparam int MIN_CNT_W = 2;

   // Run phase of the stage, used for readability in the counter.
   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } cfpwm_phase_e;
endpackage

// File: rtl/cfpwm_shadow.sv
module cfpwm_shadow #(
   parameter int CNT_W = cfpwm_pkg::DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] period_in,
   input  logic [CNT_W-1:0] on_in,
   output logic [CNT_W-1:0] act_period,
   output logic [CNT_W-1:0] act_on
);
   // Working copies: refreshed from the inputs only when load is high.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_period <= '0;
         act_on     <= '0;
      end else if (load) begin
         act_period <= period_in;
         act_on     <= on_in;
      end
   end
endmodule

// File: rtl/cfpwm_counter.sv
module cfpwm_counter #(
   parameter int CNT_W = cfpwm_pkg::DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   import cfpwm_pkg::*;

   cfpwm_phase_e phase;
   logic         at_limit;

   assign phase    = run ? PH_RUN : PH_IDLE;
   assign at_limit = (cnt == limit);
   assign wrap     = (phase == PH_RUN) && tick && at_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (phase == PH_IDLE) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= at_limit ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/cfpwm_compare.sv
module cfpwm_compare #(
   parameter int CNT_W = cfpwm_pkg::DEF_CNT_W
) (
   input  logic             run,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] on_val,
   output logic             level
);
   // High while the count is below the on value; an on value above the
   // period keeps the level high, an on value of zero keeps it low.
   always_comb begin
      level = run && (cnt < on_val);
   end
endmodule

// File: rtl/cfpwm_stage.sv
module cfpwm_stage #(
   parameter int CNT_W = cfpwm_pkg::DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] period_in,
   input  logic [CNT_W-1:0] on_in,
   output logic             pwm_out,
   output logic             cycle_end
);
   generate
      if (CNT_W < cfpwm_pkg::MIN_CNT_W) begin : g_width_bad
         $error("cfpwm_stage: CNT_W must be at least %0d", cfpwm_pkg::MIN_CNT_W);
      end
   endgenerate

   logic [CNT_W-1:0] act_period;
   logic [CNT_W-1:0] act_on;
   logic [CNT_W-1:0] cnt_q;
   logic             wrap;
   logic             shadow_load;

   // Load while idle so the first cycle uses fresh values; otherwise only at the wrap.
   assign shadow_load = !run || wrap;

   cfpwm_shadow #(.CNT_W(CNT_W)) u_shadow (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (shadow_load),
      .period_in  (period_in),
      .on_in      (on_in),
      .act_period (act_period),
      .act_on     (act_on)
   );

   cfpwm_counter #(.CNT_W(CNT_W)) u_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick),
      .limit (act_period),
      .cnt   (cnt_q),
      .wrap  (wrap)
   );

   cfpwm_compare #(.CNT_W(CNT_W)) u_compare (
      .run    (run),
      .cnt    (cnt_q),
      .on_val (act_on),
      .level  (pwm_out)
   );

   assign cycle_end = wrap;
endmodule

// File: rtl/cfpwm_stage_chk.sv
module cfpwm_stage_chk #(
   parameter int CNT_W = cfpwm_pkg::DEF_CNT_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             tick,
   input logic             pwm_out,
   input logic             cycle_end,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] act_period,
   input logic [CNT_W-1:0] act_on
);
   // R2: idle stage drives nothing
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (!pwm_out && !cycle_end));

   // R2: idle clears the count at the next edge
   a_r2_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));

   // R3: count holds without a tick
   a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> (cnt == $past(cnt)));

   // R3: strobe only on a tick
   a_r3_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_end |-> tick);

   // R4: wrap returns the count to zero
   a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_end |=> (cnt == '0));

   // R4: count never passes the working period
   a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= act_period);

   // R6: on above period keeps the level high
   a_r6_full_high: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (act_on > act_period)) |-> pwm_out);

   // R7: zero on value keeps the level low
   a_r7_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      (act_on == '0) |-> !pwm_out);

   // R8: working values move only at a wrap while running
   a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !cycle_end) |=> ($stable(act_period) && $stable(act_on)));
endmodule

bind cfpwm_stage cfpwm_stage_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run        (run),
   .tick       (tick),
   .pwm_out    (pwm_out),
   .cycle_end  (cycle_end),
   .cnt        (cnt_q),
   .act_period (act_period),
   .act_on     (act_on)
);

// File: tb/cfpwm_stage_tb.sv
module cfpwm_stage_tb;
   localparam int CLK_P = 10;
   localparam int W     = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         run = 1'b0;
   logic         tick = 1'b0;
   logic [W-1:0] period_in = '0;
   logic [W-1:0] on_in = '0;
   logic         pwm_out;
   logic         cycle_end;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic s_pwm, s_end;

   always #(CLK_P/2) clk = ~clk;

   cfpwm_stage #(.CNT_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
      .period_in(period_in), .on_in(on_in),
      .pwm_out(pwm_out), .cycle_end(cycle_end)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // One clock cycle: drive tick, sample just before the edge, step past the edge.
   task automatic cyc(input logic t);
      tick = t;
      #(CLK_P - 2);
      s_pwm = pwm_out;
      s_end = cycle_end;
      @(posedge clk);
      #1;
   endtask

   // Run ncyc cycles with a tick every div cycles; count high cycles, strobes, and strobes off-tick.
   task automatic measure(input int ncyc, input int div,
                          output int highs, output int ends, output int bad_ends);
      highs = 0; ends = 0; bad_ends = 0;
      for (int i = 0; i < ncyc; i++) begin
         logic t;
         t = ((i % div) == 0);
         cyc(t);
         if (s_pwm) highs++;
         if (s_end) begin
            ends++;
            if (!t) bad_ends++;
         end
      end
   endtask

   task automatic go_idle(input int p, input int n);
      run = 1'b0;
      period_in = W'(p);
      on_in = W'(n);
      cyc(1'b0);
      cyc(1'b1);
   endtask

   task automatic t_reset;
      #(CLK_P - 2);
      chk("R1 pwm after reset", int'(pwm_out), 0);
      chk("R1 cycle_end after reset", int'(cycle_end), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
   endtask

   task automatic t_idle;
      int h, e, b;
      go_idle(3, 2);
      measure(12, 1, h, e, b);
      chk("R2 idle high cycles", h, 0);
      chk("R2 idle strobes", e, 0);
   endtask

   task automatic t_basic;
      int h, e, b;
      go_idle(4, 2);
      run = 1'b1;
      // first cycle pattern: counts 0,1 high; 2,3,4 low; strobe at 4
      for (int i = 0; i < 5; i++) begin
         cyc(1'b1);
         chk("R5 first cycle level", int'(s_pwm), (i < 2) ? 1 : 0);
         chk("R4 strobe position", int'(s_end), (i == 4) ? 1 : 0);
      end
      measure(15, 1, h, e, b);
      chk("R5 high cycles over 3 periods", h, 6);
      chk("R4 strobes over 3 periods", e, 3);
   endtask

   task automatic t_slow_tick;
      int h, e, b;
      go_idle(3, 1);
      run = 1'b1;
      measure(24, 3, h, e, b);
      chk("R3 high cycles, tick every 3", h, 6);
      chk("R3 strobes, tick every 3", e, 2);
      chk("R3 strobes off tick", b, 0);
   endtask

   task automatic t_full;
      int h, e, b;
      go_idle(8'hFE, 8'hFF);
      run = 1'b1;
      measure(510, 1, h, e, b);
      chk("R6 on FF period FE high cycles", h, 510);
      chk("R6 strobes", e, 2);
      go_idle(4, 9);
      run = 1'b1;
      measure(10, 1, h, e, b);
      chk("R6 on 9 period 4 high cycles", h, 10);
   endtask

   task automatic t_zero;
      int h, e, b;
      go_idle(5, 0);
      run = 1'b1;
      measure(18, 1, h, e, b);
      chk("R7 zero on high cycles", h, 0);
      chk("R7 zero on strobes", e, 3);
   endtask

   task automatic t_shadow;
      int h, e, b;
      go_idle(7, 2);
      run = 1'b1;
      h = 0; e = 0;
      for (int i = 0; i < 8; i++) begin
         if (i == 3) begin
            period_in = 8'd3;
            on_in = 8'd3;
         end
         cyc(1'b1);
         if (s_pwm) h++;
         if (s_end) e++;
         if (i == 7) chk("R8 old cycle ends at count 7", int'(s_end), 1);
      end
      chk("R8 old cycle high cycles", h, 2);
      chk("R8 old cycle strobes", e, 1);
      measure(4, 1, h, e, b);
      chk("R8 new cycle high cycles", h, 3);
      chk("R8 new cycle strobes", e, 1);
   endtask

   task automatic t_restart;
      int h, e, b;
      go_idle(7, 2);
      run = 1'b1;
      for (int i = 0; i < 4; i++) cyc(1'b1);
      run = 1'b0;
      period_in = 8'd2;
      on_in = 8'd1;
      cyc(1'b1);
      chk("R2 stopped level", int'(s_pwm), 0);
      cyc(1'b0);
      run = 1'b1;
      for (int i = 0; i < 3; i++) begin
         cyc(1'b1);
         chk("R9 restart level", int'(s_pwm), (i == 0) ? 1 : 0);
         chk("R9 restart strobe", int'(s_end), (i == 2) ? 1 : 0);
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_idle();
      t_basic();
      t_slow_tick();
      t_full();
      t_zero();
      t_shadow();
      t_restart();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule